// File: doc/BRIEF.md
# Interleaved SAR Converter Phase Sequencer

This block is the digital timing and control core of an interleaved converter. The converter has sixteen successive-approximation sections that take turns. One global phase counter splits the input clock into a repeating sixteen-step cycle. Each section reads that count through its own fixed offset, so its schedule runs one clock behind its lower neighbour. Within its own cycle a section does the following, in order:

- strobes a zero-reference capture;
- strobes an auto-zero comparison;
- strobes a calibration comparison;
- opens its input sampling gate for one clock;
- spends eleven clocks on an MSB-first bit search, driven by its own comparator decision;
- hands its finished code to the shared output in its last step.

Because the schedules are staggered, exactly one section samples on every clock and one finished code leaves the block on every clock. The comparators, the reference ladder and the closed-loop correction are analog and sit outside the block. The block sees each comparator only as one decision bit per section, and drives the analog side only through strobes and trial codes.

Top module: `ileave_sar_seq`

## Requirements
- R1: A synchronous active-low reset clears the phase count to 0, every trial code to 0, `out_data` to 0 and `out_valid` to 0. Out of reset, the phase count advances by one on every clock and wraps from 15 to 0.
- R2: Section s has local step (phase - s) mod 16. `refz_stb[s]`, `az_stb[s]` and `cal_stb[s]` are high only at local steps 0, 1 and 2 respectively. Each is therefore high for one clock in every sixteen. A section never has two of its strobes high at once.
- R3: `samp_gate[s]` is high only at local step 3. In every cycle exactly one bit of `samp_gate` is high.
- R4: On the clock edge that ends a section's step 3, its trial code loads 0x400: only bit 10, the MSB, is set.
- R5: During local steps 4 to 14, the step decides bit 14 minus the step. On the edge that ends the step, that bit takes the section's comparator bit (1 keeps it, 0 clears it) and the next lower bit is set to 1. With an ideal comparator (1 when the input is at or above the trial code), the final code equals the input.
- R6: On the edge that ends the cycle in which the phase count is p, `out_data` loads the code of section (p + 1) mod 16, which is the section at local step 15.
- R7: A code appears on `out_data` exactly 12 clock edges after the edge that ends its sampling step.
- R8: `out_valid` stays 0 after reset until the edge that ends the first cycle in which the phase count is 15. From then on it is 1 on every cycle until the next reset.
- R9: A section's comparator bit has no effect outside its steps 4 to 14. Its trial code holds its value through steps 15, 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_dec | input | 16 | Comparator decision per section, 1 = input at or above the trial code |
| refz_stb | output | 16 | Zero-reference capture strobe per section |
| az_stb | output | 16 | Auto-zero comparison strobe per section |
| cal_stb | output | 16 | Calibration comparison strobe per section |
| samp_gate | output | 16 | Input sampling gate per section |
| trial_code | output | 176 | Trial DAC code per section, section s at bits [11s+10:11s] |
| out_data | output | 11 | Merged conversion result |
| out_valid | output | 1 | High while `out_data` carries a real conversion |

## Verification
The assertions check the following on every cycle:
- the phase count steps by one;
- each section's strobes are mutually exclusive;
- exactly one sampling gate is open;
- the trial code loads its MSB after a sample;
- each decided bit follows the comparator;
- trial codes hold outside the search;
- valid rises at the first phase-15 edge and then stays high.

Only the bench's scenarios can show that whole codes come out correct, from the right section, in sample order and with the 12-edge latency. To do this the bench models an ideal comparator per section and drives noise on the comparator bits outside the search. It covers ramp, zero, full-scale, mid-scale boundary and random inputs, and a reset in the middle of a stream.

// File: rtl/ileave_sar_pkg.sv
// Package: shared constants, the step-kind type and the step classifier
// for the interleaved SAR phase sequencer.
// Assumes the per-section schedule is PRE_STEPS set-up steps, then
// SAR_BITS search steps, then one transfer step, filling the full cycle.
package ileave_sar_pkg;

    // Number of set-up steps before the bit search: zero-ref, auto-zero,
    // calibrate, sample.
    localparam int PRE_STEPS = 4;

    // Local step indices of the set-up steps.
    localparam int STEP_REFZ = 0;
    localparam int STEP_AZ   = 1;
    localparam int STEP_CAL  = 2;
    localparam int STEP_SAMP = 3;

    typedef enum logic [2:0] {
        K_REFZ,
        K_AZ,
        K_CAL,
        K_SAMP,
        K_CONV,
        K_XFER
    } step_kind_t;

    // Map a local step number to what the section does in it.
    function automatic step_kind_t step_kind(input int unsigned step,
                                             input int unsigned sar_bits);
        step_kind_t k;
        if (step == STEP_REFZ)                 k = K_REFZ;
        else if (step == STEP_AZ)              k = K_AZ;
        else if (step == STEP_CAL)             k = K_CAL;
        else if (step == STEP_SAMP)            k = K_SAMP;
        else if (step < PRE_STEPS + sar_bits)  k = K_CONV;
        else                                   k = K_XFER;
        return k;
    endfunction

endpackage

// File: rtl/ileave_sar_phase_ctr.sv
// Module: global phase counter.
// Counts 0..NUM_SECT-1 and wraps; every section derives its local step
// from this single count. Assumes NUM_SECT is a power of two so the wrap
// is the natural binary rollover.
module ileave_sar_phase_ctr #(
    parameter int NUM_SECT = 16,
    localparam int PHASE_W = $clog2(NUM_SECT)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PHASE_W-1:0] phase
);

    // Advance the phase every clock; reset returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + PHASE_W'(1);
    end

    // R1: the phase steps by exactly one per clock out of reset
    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase == PHASE_W'($past(phase) + PHASE_W'(1))));

endmodule

// File: rtl/ileave_sar_section.sv
// Module: one converter section.
// Decodes its local step from the global phase and its fixed offset, drives
// its four one-clock strobes, and holds the SAR register that doubles as the
// trial DAC code. Assumes the comparator bit is valid during each search
// step and reflects the trial code presented in that step.
module ileave_sar_section
    import ileave_sar_pkg::*;
#(
    parameter int NUM_SECT = 16,
    parameter int SAR_BITS = 11,
    parameter int SECT_ID  = 0,
    localparam int PHASE_W = $clog2(NUM_SECT),
    localparam int BIT_W   = $clog2(SAR_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PHASE_W-1:0]  phase,
    input  logic                cmp,
    output logic                refz,
    output logic                az,
    output logic                cal,
    output logic                samp,
    output logic [SAR_BITS-1:0] trial
);

    localparam logic [PHASE_W-1:0]  OFFSET    = PHASE_W'(SECT_ID);
    localparam int                  CONV_LAST = PRE_STEPS + SAR_BITS - 1;
    localparam logic [SAR_BITS-1:0] MSB_ONLY  = SAR_BITS'(1) << (SAR_BITS - 1);

    logic [PHASE_W-1:0]  step;
    step_kind_t          kind;
    logic                in_conv;
    logic [BIT_W-1:0]    bit_idx;
    logic [SAR_BITS-1:0] trial_nxt;

    // Local step: this section runs SECT_ID clocks behind section 0.
    always_comb begin
        step    = phase - OFFSET;
        kind    = step_kind(int'(step), SAR_BITS);
        in_conv = (kind == K_CONV);
        bit_idx = BIT_W'(CONV_LAST - int'(step));
    end

    // Strobe decode: each set-up step raises its own line for one clock.
    always_comb begin
        refz = (kind == K_REFZ);
        az   = (kind == K_AZ);
        cal  = (kind == K_CAL);
        samp = (kind == K_SAMP);
    end

    // Search update: settle the bit under test, raise the next lower one.
    always_comb begin
        trial_nxt          = trial;
        trial_nxt[bit_idx] = cmp;
        if (bit_idx != '0) trial_nxt[bit_idx - BIT_W'(1)] = 1'b1;
    end

    // SAR register: load MSB after sampling, step during search, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       trial <= '0;
        else if (samp)    trial <= MSB_ONLY;
        else if (in_conv) trial <= trial_nxt;
    end

    // R2: at most one set-up strobe of this section at a time
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({refz, az, cal, samp}));

    // R4: the edge after the sample step leaves only the MSB set
    assert_msb_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        samp |=> (trial == MSB_ONLY));

    // R5: the bit under test takes the comparator decision
    assert_bit_decide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_conv |=> (trial[$past(bit_idx)] == $past(cmp)));

    // R9: outside sample and search steps the code does not move
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_conv && !samp) |=> $stable(trial));

endmodule

// File: rtl/ileave_sar_merge.sv
// Module: output merger.
// Registers the code of the section in its transfer step, which is the
// section one ahead of the global phase, and keeps a valid flag that rises
// at the end of the first full pass. Assumes NUM_SECT is a power of two.
module ileave_sar_merge #(
    parameter int NUM_SECT = 16,
    parameter int SAR_BITS = 11,
    localparam int PHASE_W = $clog2(NUM_SECT),
    localparam int FLAT_W  = NUM_SECT * SAR_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PHASE_W-1:0]  phase,
    input  logic [FLAT_W-1:0]   codes,
    output logic [SAR_BITS-1:0] out_data,
    output logic                out_valid
);

    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_SECT - 1);

    logic [PHASE_W-1:0] xfer_sel;

    // Transfer selection: the section at its last step is phase + 1.
    always_comb xfer_sel = phase + PHASE_W'(1);

    // Output register: one code per clock from the transferring section.
    always_ff @(posedge clk) begin
        if (!rst_n) out_data <= '0;
        else        out_data <= codes[xfer_sel * SAR_BITS +: SAR_BITS];
    end

    // Valid flag: set by the first last-phase edge, then held.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= out_valid | (phase == LAST_PHASE);
    end

    // R8: the last phase of a pass makes the output valid
    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST_PHASE) |=> out_valid);

    // R8: once valid, the output stays valid until reset
    assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

endmodule

// File: rtl/ileave_sar_seq.sv
// Module: interleaved SAR phase sequencer, top level.
// Ties the global phase counter, the staggered sections and the output
// merger together. Assumes 4 + SAR_BITS + 1 == NUM_SECT so each section's
// schedule fills exactly one phase cycle.
module ileave_sar_seq #(
    parameter int NUM_SECT = 16,
    parameter int SAR_BITS = 11,
    localparam int PHASE_W = $clog2(NUM_SECT),
    localparam int FLAT_W  = NUM_SECT * SAR_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SECT-1:0] cmp_dec,
    output logic [NUM_SECT-1:0] refz_stb,
    output logic [NUM_SECT-1:0] az_stb,
    output logic [NUM_SECT-1:0] cal_stb,
    output logic [NUM_SECT-1:0] samp_gate,
    output logic [FLAT_W-1:0]   trial_code,
    output logic [SAR_BITS-1:0] out_data,
    output logic                out_valid
);

    logic [PHASE_W-1:0] phase;

    ileave_sar_phase_ctr #(.NUM_SECT(NUM_SECT)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    // One section per slot, each offset by its index.
    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        ileave_sar_section #(
            .NUM_SECT (NUM_SECT),
            .SAR_BITS (SAR_BITS),
            .SECT_ID  (s)
        ) u_sect (
            .clk   (clk),
            .rst_n (rst_n),
            .phase (phase),
            .cmp   (cmp_dec[s]),
            .refz  (refz_stb[s]),
            .az    (az_stb[s]),
            .cal   (cal_stb[s]),
            .samp  (samp_gate[s]),
            .trial (trial_code[s*SAR_BITS +: SAR_BITS])
        );
    end

    ileave_sar_merge #(
        .NUM_SECT (NUM_SECT),
        .SAR_BITS (SAR_BITS)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .codes     (trial_code),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // R3: the staggered sections leave exactly one input gate open
    assert_one_sampler_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(samp_gate));

endmodule

// File: tb/ileave_sar_seq_bench.sv
// Bench: directed scenarios with an ideal comparator model per section.
module ileave_sar_seq_bench;

    localparam int NS  = 16;
    localparam int NB  = 11;
    localparam int MAXV = (1 << NB) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   cmp_dec = '0;
    logic [NS-1:0]   refz_stb, az_stb, cal_stb, samp_gate;
    logic [NS*NB-1:0] trial_code;
    logic [NB-1:0]   out_data;
    logic            out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cyc    = 0;
    int tgt [NS];
    int exp_q [$];
    int exp_k [$];

    always #10 clk = ~clk;

    ileave_sar_seq #(.NUM_SECT(NS), .SAR_BITS(NB)) u_ileave_sar_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_dec    (cmp_dec),
        .refz_stb   (refz_stb),
        .az_stb     (az_stb),
        .cal_stb    (cal_stb),
        .samp_gate  (samp_gate),
        .trial_code (trial_code),
        .out_data   (out_data),
        .out_valid  (out_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, expv);
        end
    endtask

    function automatic int trial_of(input int s);
        return int'(trial_code[s*NB +: NB]);
    endfunction

    function automatic int pat_val(input int pat, input int n);
        case (pat)
            0: return (n * 37) % (MAXV + 1);
            1: return 0;
            2: return MAXV;
            3: return int'($urandom_range(MAXV, 0));
            default: case (n % 4)
                0: return 1023;
                1: return 1024;
                2: return 1;
                default: return MAXV - 1;
            endcase
        endcase
    endfunction

    // Reset for two edges, release at a falling edge; that is cycle 0.
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmp_dec = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        exp_q.delete();
        exp_k.delete();
        for (int s = 0; s < NS; s++) tgt[s] = 0;
    endtask

    // Drive and check n cycles; pattern pat feeds the sampled inputs.
    task automatic run_cycles(input int pat, input int n);
        for (int i = 0; i < n; i++) begin
            int ph;
            logic [NS-1:0] e_rz, e_az, e_cal, e_smp;
            ph = cyc % NS;
            for (int s = 0; s < NS; s++) begin
                int st;
                st = (ph - s + NS) % NS;
                e_rz[s]  = (st == 0);
                e_az[s]  = (st == 1);
                e_cal[s] = (st == 2);
                e_smp[s] = (st == 3);
            end
            chk(refz_stb == e_rz, "R2 refz", int'(refz_stb), int'(e_rz));
            chk(az_stb == e_az, "R2 az", int'(az_stb), int'(e_az));
            chk(cal_stb == e_cal, "R2 cal", int'(cal_stb), int'(e_cal));
            chk(samp_gate == e_smp, "R3 gate", int'(samp_gate), int'(e_smp));
            // R4: section that sampled last cycle now shows MSB only
            if (cyc >= 1)
                chk(trial_of((ph - 4 + NS) % NS) == 'h400, "R4 msb",
                    trial_of((ph - 4 + NS) % NS), 'h400);
            // R8: valid from the edge ending phase 15 of the first pass
            chk(out_valid == (cyc >= NS), "R8 valid", int'(out_valid), int'(cyc >= NS));
            if (out_valid && exp_q.size() > 0) begin
                int ev, ek;
                ev = exp_q.pop_front();
                ek = exp_k.pop_front();
                chk(int'(out_data) == ev, "R5/R6 data", int'(out_data), ev);
                chk(cyc - ek == 13, "R7 latency", cyc - ek, 13);
            end
            if (cyc >= 3) begin
                int v;
                v = pat_val(pat, cyc);
                tgt[(ph - 3 + NS) % NS] = v;
                exp_q.push_back(v);
                exp_k.push_back(cyc);
            end
            // Ideal comparator during search; noise otherwise (R9)
            for (int s = 0; s < NS; s++) begin
                int st;
                st = (ph - s + NS) % NS;
                if (st >= 4 && st <= 14) cmp_dec[s] = (tgt[s] >= trial_of(s));
                else                     cmp_dec[s] = 1'($urandom_range(1, 0));
            end
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic test_reset_state();
        apply_reset();
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(out_data == '0, "R1 data", int'(out_data), 0);
        chk(trial_code == '0, "R1 trial", int'(trial_code[31:0]), 0);
        chk(samp_gate == NS'(1 << 13), "R1 phase0", int'(samp_gate), 1 << 13);
        run_cycles(1, 20);
    endtask

    task automatic test_ramp();
        apply_reset();
        run_cycles(0, 120);
    endtask

    task automatic test_extremes();
        apply_reset();
        run_cycles(1, 60);
        apply_reset();
        run_cycles(2, 60);
    endtask

    task automatic test_boundary();
        apply_reset();
        run_cycles(4, 100);
    endtask

    task automatic test_random();
        apply_reset();
        run_cycles(3, 400);
    endtask

    // Reset mid-stream: valid must drop and the latency restart.
    task automatic test_midreset();
        apply_reset();
        run_cycles(3, 37);
        apply_reset();
        chk(out_valid == 1'b0, "R8 midreset", int'(out_valid), 0);
        run_cycles(0, 50);
    endtask

    initial begin
        test_reset_state();
        test_ramp();
        test_extremes();
        test_boundary();
        test_random();
        test_midreset();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule